// File: doc/BRIEF.md
# Cascaded Interrupt Aggregation Controller

The block merges 96 interrupt sources into a single CPU interrupt request. Sources arrive in three 32-bit words. A low main word carries internal unit requests. A high main word carries further unit requests. A second-level port word latches rising edges seen on 32 asynchronous general-purpose pins. Four summary bits in the high word stand in for the port word, one bit per group of eight pins. A per-word constant filter removes reserved positions, and each word also has a software mask.

Software reaches the masks and the port cause word through a small register port. It can also enable or disable a single interrupt number through a one-cycle command. The claim output always shows the number of the interrupt to service. That is the lowest-numbered pending and enabled source, searched in the order low word, high word, port word. When nothing qualifies, the claim shows a fixed spurious code. A registered request line follows the claim by one cycle.

Top module: `icag_top`

## Requirements
- R1: After reset the low mask and port mask read 0, the high mask reads 0x0F000000, the port cause word reads 0, `irq_o` is 0 and the claim shows the spurious code.
- R2: Low-word positions outside 0x3DFFFFFE (bits 0, 25, 30, 31) are never claimed, even when pending and unmasked.
- R3: High-word positions outside 0x0F000DB7 are never claimed. A pending, unmasked high bit k inside that set claims 32+k.
- R4: The claim is the lowest qualifying number. Any qualifying low bit beats every high bit, and any qualifying high bit below bit 24 beats the port word.
- R5: With no qualifying source, `claim_id_o` reads -2 (8-bit two's complement 0xFE). Otherwise it lies in 0..95.
- R6: High bit 24+g (g = 0..3) is set when any port bit in 8g..8g+7 is both latched and unmasked. When such a summary bit wins, the claim is 64 plus the lowest latched, unmasked port bit.
- R7: A command with number n (0..95) sets (`cmd_set_i`=1) or clears mask bit n mod 32 of word n/32 and leaves every other mask bit unchanged. A command with n ≥ 96 changes no mask.
- R8: A port cause bit sets one cycle after a rising edge reaches the end of a two-flop synchronizer, and stays set until cleared. A register write to the cause word clears each bit written 0 and keeps each bit written 1.
- R9: A port edge arriving in the same cycle as a clear write to its bit leaves the bit set.
- R10: `irq_o` equals, one clock later, whether the claim differed from the spurious code.
- R11: Register map on `reg_addr_i`: 0 low mask, 1 high mask, 2 port mask, 3 port cause (write-0-to-clear), 4 raw low word (read-only), 5 high word with summary bits in 24..27 (read-only). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lo_src_i | input | 32 | Low main cause word, level requests |
| hi_src_i | input | 32 | High main cause word, level requests (bits 24..27 replaced by summaries) |
| port_pin_i | input | 32 | Asynchronous general-purpose port pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| cmd_valid_i | input | 1 | Single-number enable/disable command strobe |
| cmd_set_i | input | 1 | 1 enables, 0 disables |
| cmd_num_i | input | 7 | Interrupt number of the command |
| claim_id_o | output | 8 | Signed claimed number or -2 |
| irq_o | output | 1 | Registered CPU interrupt request |

## Verification
The assertions assume the low and high cause inputs are plain levels, sampled the same cycle they change. They also assume port pins move no more than once every few cycles, so each edge crosses the synchronizer cleanly. The stimulus changes every input at the falling clock edge, holds pins stable for several cycles around each edge, and never issues a register write and a command in the same cycle. The one deliberate collision is a clear write placed exactly in the cycle a port edge leaves the synchronizer.

// File: rtl/icag_pkg.sv
package icag_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 3;
  localparam int NUM_SRC    = WORD_W * NUM_WORDS;
  localparam int ID_W       = 8;
  localparam int SUM_LSB    = 24;
  localparam int GROUP_W    = 8;
  localparam int NUM_GROUPS = WORD_W / GROUP_W;
  localparam int IDX_W      = $clog2(WORD_W);

  localparam logic [WORD_W-1:0] LO_KEEP     = 32'h3DFF_FFFE;
  localparam logic [WORD_W-1:0] HI_KEEP     = 32'h0F00_0DB7;
  localparam logic [WORD_W-1:0] HI_MASK_RST = 32'h0F00_0000;
  localparam logic signed [ID_W-1:0] SPURIOUS = -8'sd2;

  typedef enum logic [2:0] {
    RA_LO_MASK    = 3'd0,
    RA_HI_MASK    = 3'd1,
    RA_PORT_MASK  = 3'd2,
    RA_PORT_CAUSE = 3'd3,
    RA_LO_WORD    = 3'd4,
    RA_HI_WORD    = 3'd5
  } reg_addr_e;

  // {found, index} of lowest set bit
  function automatic logic [IDX_W:0] find_lowest(input logic [WORD_W-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/icag_port_cause.sv
module icag_port_cause
  import icag_pkg::*;
#(
  parameter int W           = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] keep;
  logic [W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign keep = clr_wr_i ? clr_data_i : '1;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & keep) | rise;
  end

  assign cause_o = cause_q;

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_q & $past(rise)) == $past(rise))); // R9

  AST_NO_SPONT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~cause_q & $past(cause_q)) != '0) |-> $past(clr_wr_i)); // R8
endmodule

// File: rtl/icag_mask_regs.sv
module icag_mask_regs
  import icag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_set_i,
  input  logic [6:0]        cmd_num_i,
  output logic [WORD_W-1:0] lo_mask_o,
  output logic [WORD_W-1:0] hi_mask_o,
  output logic [WORD_W-1:0] port_mask_o
);
  logic [WORD_W-1:0] mask_w [NUM_WORDS];
  logic              cmd_ok;

  assign cmd_ok = cmd_valid_i && (cmd_num_i < 7'(NUM_SRC));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] RST_VAL = (w == 1) ? HI_MASK_RST : '0;
    logic              reg_hit;
    logic              cmd_hit;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] q;

    assign reg_hit = reg_wr_i && (reg_addr_i == 3'(w));
    assign cmd_hit = cmd_ok && (cmd_num_i[6:5] == 2'(w));

    always_comb begin
      nxt = q;
      if (reg_hit) nxt = reg_wdata_i;
      if (cmd_hit) nxt[cmd_num_i[4:0]] = cmd_set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else         q <= nxt;
    end

    assign mask_w[w] = q;
  end

  assign lo_mask_o   = mask_w[0];
  assign hi_mask_o   = mask_w[1];
  assign port_mask_o = mask_w[2];

  AST_CMD_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && !reg_wr_i) |->
      ($countones({lo_mask_o, hi_mask_o, port_mask_o} ^
                  $past({lo_mask_o, hi_mask_o, port_mask_o})) <= 1)); // R7

  AST_CMD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && !reg_wr_i && cmd_num_i >= 7'(NUM_SRC)) |->
      $stable({lo_mask_o, hi_mask_o, port_mask_o})); // R7
endmodule

// File: rtl/icag_claim_arb.sv
module icag_claim_arb
  import icag_pkg::*;
(
  input  logic [WORD_W-1:0]      lo_src_i,
  input  logic [WORD_W-1:0]      hi_src_i,
  input  logic [WORD_W-1:0]      port_cause_i,
  input  logic [WORD_W-1:0]      lo_mask_i,
  input  logic [WORD_W-1:0]      hi_mask_i,
  input  logic [WORD_W-1:0]      port_mask_i,
  output logic [WORD_W-1:0]      hi_word_o,
  output logic signed [ID_W-1:0] claim_o
);
  logic [WORD_W-1:0]     port_act;
  logic [NUM_GROUPS-1:0] summary;
  logic [WORD_W-1:0]     lo_act;
  logic [WORD_W-1:0]     hi_act;
  logic [IDX_W:0]        lo_hit;
  logic [IDX_W:0]        hi_hit;
  logic [IDX_W:0]        pt_hit;
  logic                  hi_is_sum;

  assign port_act = port_cause_i & port_mask_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sum
    assign summary[g] = |port_act[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    hi_word_o = hi_src_i;
    hi_word_o[SUM_LSB +: NUM_GROUPS] = summary;
  end

  assign lo_act = lo_src_i & LO_KEEP & lo_mask_i;
  assign hi_act = hi_word_o & HI_KEEP & hi_mask_i;

  assign lo_hit = find_lowest(lo_act);
  assign hi_hit = find_lowest(hi_act);
  assign pt_hit = find_lowest(port_act);

  assign hi_is_sum = (hi_hit[IDX_W-1:0] >= IDX_W'(SUM_LSB)) &&
                     (hi_hit[IDX_W-1:0] <  IDX_W'(SUM_LSB + NUM_GROUPS));

  always_comb begin
    if (lo_hit[IDX_W])
      claim_o = {3'b000, lo_hit[IDX_W-1:0]};
    else if (hi_hit[IDX_W] && hi_is_sum && pt_hit[IDX_W])
      claim_o = {3'b010, pt_hit[IDX_W-1:0]};
    else if (hi_hit[IDX_W])
      claim_o = {3'b001, hi_hit[IDX_W-1:0]};
    else
      claim_o = SPURIOUS;
  end
endmodule

// File: rtl/icag_top.sv
module icag_top
  import icag_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [31:0]            lo_src_i,
  input  logic [31:0]            hi_src_i,
  input  logic [31:0]            port_pin_i,
  input  logic                   reg_wr_i,
  input  logic [2:0]             reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic                   cmd_valid_i,
  input  logic                   cmd_set_i,
  input  logic [6:0]             cmd_num_i,
  output logic signed [7:0]      claim_id_o,
  output logic                   irq_o
);
  logic [WORD_W-1:0] lo_mask;
  logic [WORD_W-1:0] hi_mask;
  logic [WORD_W-1:0] port_mask;
  logic [WORD_W-1:0] port_cause;
  logic [WORD_W-1:0] hi_word;
  logic              cause_wr;
  logic              irq_q;

  assign cause_wr = reg_wr_i && (reg_addr_i == RA_PORT_CAUSE);

  icag_mask_regs u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_set_i   (cmd_set_i),
    .cmd_num_i   (cmd_num_i),
    .lo_mask_o   (lo_mask),
    .hi_mask_o   (hi_mask),
    .port_mask_o (port_mask)
  );

  icag_port_cause #(.W(WORD_W), .SYNC_STAGES(2)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (port_pin_i),
    .clr_wr_i   (cause_wr),
    .clr_data_i (reg_wdata_i),
    .cause_o    (port_cause)
  );

  icag_claim_arb u_arb (
    .lo_src_i     (lo_src_i),
    .hi_src_i     (hi_src_i),
    .port_cause_i (port_cause),
    .lo_mask_i    (lo_mask),
    .hi_mask_i    (hi_mask),
    .port_mask_i  (port_mask),
    .hi_word_o    (hi_word),
    .claim_o      (claim_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (claim_id_o != SPURIOUS);
  end
  assign irq_o = irq_q;

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      RA_LO_MASK:    reg_rdata_o = lo_mask;
      RA_HI_MASK:    reg_rdata_o = hi_mask;
      RA_PORT_MASK:  reg_rdata_o = port_mask;
      RA_PORT_CAUSE: reg_rdata_o = port_cause;
      RA_LO_WORD:    reg_rdata_o = lo_src_i;
      RA_HI_WORD:    reg_rdata_o = hi_word;
      default:       reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(claim_id_o != SPURIOUS)); // R10

  AST_CLAIM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_id_o == SPURIOUS) || (claim_id_o >= 8'sd0 && claim_id_o < 8'sd96)); // R5

  AST_LO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_id_o >= 8'sd0 && claim_id_o < 8'sd32) |-> LO_KEEP[claim_id_o[4:0]]); // R2

  AST_HI_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_id_o >= 8'sd32 && claim_id_o < 8'sd64) |->
      (HI_KEEP[claim_id_o[4:0]] && hi_mask[claim_id_o[4:0]])); // R3

  AST_PORT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_id_o >= 8'sd64) |->
      (port_mask[claim_id_o[4:0]] && port_cause[claim_id_o[4:0]])); // R6

  AST_LO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lo_src_i & LO_KEEP & lo_mask) != '0) |->
      (claim_id_o >= 8'sd0 && claim_id_o < 8'sd32)); // R4
endmodule

// File: tb/tb_icag_top.sv
module tb_icag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lo_src = '0;
  logic [31:0] hi_src = '0;
  logic [31:0] pins = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_set = 1'b0;
  logic [6:0]  cmd_num = '0;
  logic signed [7:0] claim;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  icag_top dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lo_src_i    (lo_src),
    .hi_src_i    (hi_src),
    .port_pin_i  (pins),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .cmd_valid_i (cmd_valid),
    .cmd_set_i   (cmd_set),
    .cmd_num_i   (cmd_num),
    .claim_id_o  (claim),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_claim(input string req, input logic [7:0] exp);
    #1 chk(req, "claim", {24'h0, claim}, {24'h0, exp});
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cmd(input logic set, input int num);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_set = set; cmd_num = 7'(num);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1", "lo mask", d, 32'h0);
    rd(3'd1, d); chk("R1", "hi mask", d, 32'h0F00_0000);
    rd(3'd2, d); chk("R1", "port mask", d, 32'h0);
    rd(3'd3, d); chk("R1", "port cause", d, 32'h0);
    rd(3'd7, d); chk("R11", "unused addr", d, 32'h0);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
    chk_claim("R5", 8'hFE);
  endtask

  task automatic t_low;
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); lo_src = 32'hC200_0001;
    chk_claim("R2", 8'hFE);
    @(negedge clk); #1 chk("R5", "irq idle", {31'h0, irq}, 32'h0);
    @(negedge clk); lo_src = 32'hC200_1081;
    chk_claim("R4", 8'h07);
    chk("R10", "irq before edge", {31'h0, irq}, 32'h0);
    @(negedge clk); #1 chk("R10", "irq after edge", {31'h0, irq}, 32'h1);
    @(negedge clk); lo_src = 32'h0;
    #1 chk("R10", "irq holds", {31'h0, irq}, 32'h1);
    @(negedge clk); #1 chk("R10", "irq drops", {31'h0, irq}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_high;
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk); hi_src = 32'hF0FF_F248;
    chk_claim("R3", 8'hFE);
    @(negedge clk); hi_src = 32'hF0FF_F258;
    chk_claim("R3", 8'h24);
    lo_src = 32'h0010_0000;
    cmd(1'b1, 20);
    chk_claim("R4", 8'h14);
    rd(3'd4, d); chk("R11", "low word read", d, 32'h0010_0000);
    @(negedge clk); lo_src = '0; hi_src = '0;
    wr(3'd1, 32'h0F00_0000);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    cmd(1'b1, 74);
    rd(3'd2, d); chk("R7", "port mask set", d, 32'h0000_0400);
    rd(3'd1, d); chk("R7", "hi mask untouched", d, 32'h0F00_0000);
    rd(3'd0, d); chk("R7", "lo mask untouched", d, 32'h0);
    cmd(1'b1, 100);
    rd(3'd0, d); chk("R7", "oob lo", d, 32'h0);
    rd(3'd1, d); chk("R7", "oob hi", d, 32'h0F00_0000);
    rd(3'd2, d); chk("R7", "oob port", d, 32'h0000_0400);
    cmd(1'b0, 57);
    rd(3'd1, d); chk("R7", "hi mask clear", d, 32'h0D00_0000);
    cmd(1'b1, 57);
    rd(3'd1, d); chk("R7", "hi mask restore", d, 32'h0F00_0000);
  endtask

  task automatic t_port;
    logic [31:0] d;
    @(negedge clk); pins = 32'h0000_0408;
    repeat (5) @(negedge clk);
    rd(3'd3, d); chk("R8", "cause latched", d, 32'h0000_0408);
    chk_claim("R6", 8'h4A);
    chk("R6", "irq port", {31'h0, irq}, 32'h1);
    rd(3'd5, d); chk("R6", "summary group1", d, 32'h0200_0000);
    cmd(1'b1, 67);
    chk_claim("R6", 8'h43);
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);
    rd(3'd3, d); chk("R8", "cause sticky", d, 32'h0000_0408);
    wr(3'd3, ~32'h0000_0008);
    rd(3'd3, d); chk("R8", "write0 clears", d, 32'h0000_0400);
    chk_claim("R6", 8'h4A);
    cmd(1'b0, 57);
    chk_claim("R6", 8'hFE);
    @(negedge clk); #1 chk("R6", "irq off", {31'h0, irq}, 32'h0);
    cmd(1'b1, 57);
    @(negedge clk); hi_src = 32'h0000_0800;
    cmd(1'b1, 43);
    chk_claim("R4", 8'h2B);
    @(negedge clk); hi_src = '0;
    cmd(1'b0, 43);
    chk_claim("R4", 8'h4A);
  endtask

  task automatic t_edge_clear;
    logic [31:0] d;
    @(negedge clk); pins = 32'h0000_0400;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0;
    @(negedge clk); reg_wr = 1'b0;
    rd(3'd3, d); chk("R9", "edge beats clear", d, 32'h0000_0400);
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R8", "clear with pin high", d, 32'h0);
    chk_claim("R5", 8'hFE);
    @(negedge clk); pins = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low();
    t_high();
    t_cmd();
    t_port();
    t_edge_clear();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule